// File: doc/BRIEF.md
# Grouped Channel Output Disable Unit

This block sits between the output drivers of a bank of timer channels and the device pins. Its job is to push chosen channel outputs to a safe level when an external emergency-disable input goes high. The bank has 32 channels, split into four groups of eight. Each group answers to one disable input of its own.

Each channel holds two configuration bits. The enable bit decides whether the channel listens to its group's disable input. The polarity bit gives the channel's active level, and the level forced under a disable is the inverse of it. A channel that is not enabled, or whose group disable is low, passes its raw output to its pin with no delay.

The disable inputs come from outside the clock domain, so each passes through a two-flop synchronizer before it is used. Forcing holds only while the synchronized input stays high, and nothing is latched. A small address/data/write-enable port writes the per-channel configuration words and reads them back. The group count is a parameter: a two-engine build with eight inputs and 64 channels keeps the same eight-channel grouping.

Top module: `chan_out_disable`

## Requirements
- R1: While reset is asserted and after its release, every configuration word reads as 0, and each pin_o bit equals the matching ch_raw_i bit whatever dis_i is.
- R2: A configuration word is 2 bits, with bit 1 the enable and bit 0 the polarity. A write with cfg_we_i high at a rising edge stores cfg_wdata_i at channel cfg_addr_i. cfg_rdata_o shows the word at cfg_addr_i combinationally, from the cycle after the write.
- R3: Disable input g governs channels 8*g to 8*g+7: input 0 covers 0-7, input 1 covers 8-15, input 2 covers 16-23 and input 3 covers 24-31.
- R4: An enabled channel whose group's synchronized disable is high drives its pin to the complement of its polarity bit.
- R5: A channel with its enable bit at 0 passes ch_raw_i to pin_o unchanged, whatever its group disable and polarity bit hold.
- R6: A disable input that goes high is seen only after two rising edges. pin_o has not changed after the first edge and is forced after the second.
- R7: Release follows the disable input with the same two-edge latency, and no forcing is held once the input is low.
- R8: Raising one disable input never changes a pin outside that input's group of eight.
- R9: A pin that is not forced follows ch_raw_i combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dis_i | input | 4 | Asynchronous active-high disable inputs, one per group |
| ch_raw_i | input | 32 | Raw outputs from the channel drivers |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 5 | Channel index for write and read |
| cfg_wdata_i | input | 2 | Write data: bit 1 enable, bit 0 polarity |
| cfg_rdata_o | output | 2 | Configuration word at cfg_addr_i |
| pin_o | output | 32 | Final pin outputs |

## Verification
The clocked properties assume that dis_i is low while reset is asserted and stays low for at least two cycles after release. Without that, the two-cycle look-back would cover cycles in which the synchronizer was still held in reset. They also assume that no configuration write lands while the internal reset is still being released. The stimulus follows both rules. It holds dis_i at zero through reset and the settling cycles, and it issues writes only on falling edges, well after release, so every write is sampled cleanly at the next rising edge.

// File: rtl/cod_pkg.sv
package cod_pkg;
  // Per-channel configuration word layout
  localparam int CFG_W       = 2;
  localparam int CFG_EN_BIT  = 1;
  localparam int CFG_POL_BIT = 0;

  typedef struct packed {
    logic en;
    logic pol;
  } ch_cfg_t;
endpackage

// File: rtl/cod_rst_sync.sv
module cod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cod_sync.sv
module cod_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;
  logic [STAGES-1:0][WIDTH-1:0] st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cod_cfg_regs.sv
module cod_cfg_regs
  import cod_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pol_o
);
  ch_cfg_t [NUM_CH-1:0] cfg_q;
  ch_cfg_t [NUM_CH-1:0] cfg_d;
  logic    [NUM_CH-1:0] wr_sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_sel[c] = we_i && (addr_i == ADDR_W'(c));

    always_comb begin
      cfg_d[c] = cfg_q[c];
      if (wr_sel[c]) begin
        cfg_d[c].en  = wdata_i[CFG_EN_BIT];
        cfg_d[c].pol = wdata_i[CFG_POL_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[c] <= '0;
      else if (wr_sel[c]) cfg_q[c] <= cfg_d[c];
    end

    assign en_o[c]  = cfg_q[c].en;
    assign pol_o[c] = cfg_q[c].pol;
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CFG_EN_BIT]  = cfg_q[addr_i].en;
    rdata_o[CFG_POL_BIT] = cfg_q[addr_i].pol;
  end
endmodule

// File: rtl/cod_force.sv
module cod_force #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE
) (
  input  logic [NUM_GROUPS-1:0] dis_sync_i,
  input  logic [NUM_CH-1:0]     raw_i,
  input  logic [NUM_CH-1:0]     en_i,
  input  logic [NUM_CH-1:0]     pol_i,
  output logic [NUM_CH-1:0]     pin_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < GROUP_SIZE; k++) begin : g_ch
      localparam int C = g * GROUP_SIZE + k;
      logic forced;
      assign forced   = dis_sync_i[g] & en_i[C];
      assign pin_o[C] = forced ? ~pol_i[C] : raw_i[C];
    end
  end
endmodule

// File: rtl/chan_out_disable.sv
module chan_out_disable
  import cod_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] dis_i,
  input  logic [NUM_CH-1:0]     ch_raw_i,
  input  logic                  cfg_we_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [CFG_W-1:0]      cfg_wdata_i,
  output logic [CFG_W-1:0]      cfg_rdata_o,
  output logic [NUM_CH-1:0]     pin_o
);
  logic                  rst_n_int;
  logic [NUM_GROUPS-1:0] dis_sync;
  logic [NUM_CH-1:0]     cfg_en;
  logic [NUM_CH-1:0]     cfg_pol;

  cod_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cod_sync #(.WIDTH(NUM_GROUPS), .STAGES(SYNC_STAGES)) u_dis_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (dis_i),
    .q_o   (dis_sync)
  );

  cod_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .en_o    (cfg_en),
    .pol_o   (cfg_pol)
  );

  cod_force #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_force (
    .dis_sync_i (dis_sync),
    .raw_i      (ch_raw_i),
    .en_i       (cfg_en),
    .pol_i      (cfg_pol),
    .pin_o      (pin_o)
  );
endmodule

// File: rtl/chan_out_disable_chk.sv
module chan_out_disable_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_GROUPS-1:0] dis_i,
  input logic [NUM_CH-1:0]     ch_raw_i,
  input logic                  cfg_we_i,
  input logic [ADDR_W-1:0]     cfg_addr_i,
  input logic [1:0]            cfg_wdata_i,
  input logic [1:0]            cfg_rdata_o,
  input logic [NUM_CH-1:0]     pin_o,
  input logic [NUM_CH-1:0]     cfg_en,
  input logic [NUM_CH-1:0]     cfg_pol
);
  // R2: a write shows up on the read port on the next cycle at the same address
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (cfg_addr_i != $past(cfg_addr_i)) || (cfg_rdata_o == $past(cfg_wdata_i)));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < GROUP_SIZE; k++) begin : g_ch
      localparam int C = g * GROUP_SIZE + k;
      // R5: an opted-out channel always passes its raw value
      a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[C] |-> pin_o[C] == ch_raw_i[C]);
      // R4/R6: input held high two edges ago forces the enabled channel
      a_r4_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en[C] && $past(dis_i[g], 2)) |-> pin_o[C] == ~cfg_pol[C]);
      // R7: input low two edges ago releases the channel
      a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dis_i[g], 2) |-> pin_o[C] == ch_raw_i[C]);
    end
  end
endmodule

bind chan_out_disable chan_out_disable_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dis_i       (dis_i),
  .ch_raw_i    (ch_raw_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .pin_o       (pin_o),
  .cfg_en      (cfg_en),
  .cfg_pol     (cfg_pol)
);

// File: tb/chan_out_disable_bench.sv
module chan_out_disable_bench;
  localparam int NG = 4;
  localparam int GS = 8;
  localparam int NC = NG * GS;

  logic          clk;
  logic          rst_n;
  logic [NG-1:0] dis_i;
  logic [NC-1:0] ch_raw_i;
  logic          cfg_we_i;
  logic [4:0]    cfg_addr_i;
  logic [1:0]    cfg_wdata_i;
  logic [1:0]    cfg_rdata_o;
  logic [NC-1:0] pin_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NC-1:0] m_en;
  logic [NC-1:0] m_pol;

  chan_out_disable u_chan_out_disable (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .ch_raw_i(ch_raw_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .pin_o(pin_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Stimulus vectors: {dis, raw}
  localparam logic [35:0] VEC [8] = '{
    {4'b0000, 32'hA5A5_5A5A},
    {4'b0001, 32'hFFFF_FFFF},
    {4'b0010, 32'h0000_0000},
    {4'b0100, 32'h1234_5678},
    {4'b1000, 32'hDEAD_BEEF},
    {4'b1111, 32'h0F0F_F0F0},
    {4'b1010, 32'hCAFE_0123},
    {4'b0101, 32'h8000_0001}
  };

  function automatic logic [NC-1:0] model(input logic [NG-1:0] d, input logic [NC-1:0] r);
    logic [NC-1:0] o;
    for (int c = 0; c < NC; c++)
      o[c] = (m_en[c] && d[c / GS]) ? ~m_pol[c] : r[c];
    return o;
  endfunction

  task automatic check(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input logic [1:0] w);
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = 5'(ch); cfg_wdata_i = w;
    @(negedge clk);
    cfg_we_i = 0;
    m_en[ch] = w[1]; m_pol[ch] = w[0];
  endtask

  task automatic settle(input logic [NG-1:0] d, input logic [NC-1:0] r);
    @(negedge clk);
    dis_i = d; ch_raw_i = r;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 0; dis_i = 0; ch_raw_i = 32'h3C3C_C3C3;
    cfg_we_i = 0; cfg_addr_i = 0; cfg_wdata_i = 0;
    m_en = '0; m_pol = '0;
    repeat (3) @(negedge clk);
    // R1: pass-through during reset
    check("R1 reset pass", pin_o, ch_raw_i);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1: all configuration words read zero
    for (int c = 0; c < NC; c++) begin
      cfg_addr_i = 5'(c); #1;
      check("R1 cfg reset", {30'b0, cfg_rdata_o}, 32'h0);
    end
    // R1: disables have no effect with default configuration
    settle(4'b1111, 32'h5555_AAAA);
    check("R1 default no force", pin_o, 32'h5555_AAAA);
    settle(4'b0000, 32'h5555_AAAA);

    // R2: program a pattern and read it back
    for (int c = 0; c < NC; c++)
      cfg_write(c, {1'(c % 3 != 0), 1'(c % 2)});
    for (int c = 0; c < NC; c++) begin
      cfg_addr_i = 5'(c); #1;
      check("R2 readback", {30'b0, cfg_rdata_o}, {30'b0, m_en[c], m_pol[c]});
    end

    // R3/R4/R5: table walk
    foreach (VEC[i]) begin
      settle(VEC[i][35:32], VEC[i][31:0]);
      check("R3 R4 R5 vector", pin_o, model(VEC[i][35:32], VEC[i][31:0]));
    end
    settle(4'b0000, 32'h0);

    // R8: all enabled, alternating polarity, each group alone
    for (int c = 0; c < NC; c++) cfg_write(c, {1'b1, 1'(c % 2)});
    for (int g = 0; g < NG; g++) begin
      logic [NC-1:0] outside;
      logic [NC-1:0] raw;
      raw = 32'h9696_6969 ^ NC'(g * 32'h1111_1111);
      outside = ~(NC'(8'hFF) << (g * GS));
      settle(NG'(1) << g, raw);
      check("R8 isolation", pin_o & outside, raw & outside);
      check("R3 group bounds", pin_o & ~outside, model(NG'(1) << g, raw) & ~outside);
    end

    // R6/R7: latency of assert and release
    settle(4'b0000, 32'h0000_0000);
    @(negedge clk); dis_i = 4'b0001;
    @(negedge clk); #1;
    check("R6 not after one edge", pin_o, 32'h0);
    @(negedge clk); #1;
    check("R6 forced after two edges", pin_o, model(4'b0001, 32'h0));
    dis_i = 4'b0000;
    @(negedge clk); #1;
    check("R7 held one edge", pin_o, model(4'b0001, 32'h0));
    @(negedge clk); #1;
    check("R7 released", pin_o, 32'h0);

    // R5: disable one channel in a forced group
    cfg_write(3, 2'b01);
    settle(4'b0001, 32'h0000_0008);
    check("R5 opted out", pin_o, model(4'b0001, 32'h0000_0008));

    // R9: raw changes pass in the same cycle for unforced pins
    @(negedge clk); ch_raw_i = 32'hFFFF_FF08; #1;
    check("R9 comb pass", pin_o, model(4'b0001, 32'hFFFF_FF08));
    settle(4'b0000, 32'h0);

    done = 1;
    summary();
  end
endmodule